// File: doc/BRIEF.md
# 8-bit ALU with processor status flags

This block is the data path and flag logic of an 8-bit accumulator processor. Each cycle it takes an operation code, a register operand and a memory operand. It combines them with the status byte it holds and returns the result in the same cycle. When the operation is marked valid, the block writes the new status byte on the next rising clock edge. The flag rules differ for each operation. Arithmetic changes four flags. Logic and load operations change only sign and zero. The bit test copies operand bits into the sign and overflow flags. Explicit flag operations change a single flag.

Carry is always an input to add and subtract. Subtract treats carry as an inverted borrow. The surrounding sequencer chooses which register feeds `a_i`. Accumulator-mode shifts, increments and loads take their operand from `m_i`. The status byte can be loaded from a pulled stack byte and exported in its pushed form.

Top module: `acc_alu_flags`

## Requirements
- R1: While `rst_n` is low, `status_o` reads 0x24: only the interrupt mask and the constant bit are set.
- R2: Status layout: sign N bit 7, overflow V bit 6, constant 1 bit 5, break bit 4 (reads 0), decimal D bit 3, interrupt mask I bit 2, zero Z bit 1, carry C bit 0. Bit 5 always reads 1 and bit 4 always reads 0.
- R3: `result_o` is combinational from the current inputs. `status_o` takes its new value on the rising edge where `op_valid` is high. When `op_valid` is low it holds.
- R4: Add (code 0) gives A+M+C. Subtract (code 1) gives A+~M+C, so C=1 afterwards means no borrow. C is the carry out. V is set when both addends share a sign that the result lacks. N and Z follow the result.
- R5: AND (2), OR (3), XOR (4), increment M (11), decrement M (12) and load M (13) update only N and Z from the result.
- R6: Bit test (5) leaves the result equal to A, copies M bit 7 into N and M bit 6 into V, and sets Z when A AND M is zero. C, D and I are unchanged.
- R7: Shift left (6), shift right (7), rotate left (8) and rotate right (9) act on M. They update N, Z and C, with the shifted-out bit as the new C. The rotates put the old C into the vacated bit.
- R8: Compare (10) leaves the result equal to A. It sets C when A >= M unsigned, sets Z when A == M, and takes N from bit 7 of A-M. V, D and I are unchanged.
- R9: Stack-pointer transfer (14) passes M to the result and changes no flag. The flag operations (clear C 15, set C 16, clear I 17, set I 18, clear D 19, set D 20, clear V 21) each change only their own flag and pass A to the result.
- R10: Status pull (22) loads the status from M but ignores M bits 5 and 4. Status push (23) outputs the status byte with bit 4 set as the result.
- R11: Codes 24 to 31 change no flag and pass A to the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Commit the operation's status update this cycle |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | Register operand (A, X or Y) |
| m_i | input | 8 | Memory or second operand |
| result_o | output | 8 | Operation result |
| status_o | output | 8 | Current status byte |

## Verification
The assertions assume that `op_valid` and the operand buses are stable around each rising edge. They also assume that reset is held for at least one edge before any valid operation. The stimulus changes inputs only on falling edges. It lowers `op_valid` between operations and keeps every operation valid for exactly one edge. Before each operation, a status pull loads a chosen status byte, so the bench knows the incoming carry and untouched flags exactly.

// File: rtl/alu_pkg.sv
package alu_pkg;
   localparam int SBIT_C = 0;
   localparam int SBIT_Z = 1;
   localparam int SBIT_I = 2;
   localparam int SBIT_D = 3;
   localparam int SBIT_B = 4;
   localparam int SBIT_K = 5;
   localparam int SBIT_V = 6;
   localparam int SBIT_N = 7;
   localparam int STAT_W = 8;

   typedef enum logic [4:0] {
      OP_ADC = 5'd0,  OP_SBC = 5'd1,  OP_AND = 5'd2,  OP_ORA = 5'd3,
      OP_EOR = 5'd4,  OP_BIT = 5'd5,  OP_ASL = 5'd6,  OP_LSR = 5'd7,
      OP_ROL = 5'd8,  OP_ROR = 5'd9,  OP_CMP = 5'd10, OP_INC = 5'd11,
      OP_DEC = 5'd12, OP_LDM = 5'd13, OP_TXS = 5'd14, OP_CLC = 5'd15,
      OP_SEC = 5'd16, OP_CLI = 5'd17, OP_SEI = 5'd18, OP_CLD = 5'd19,
      OP_SED = 5'd20, OP_CLV = 5'd21, OP_PLP = 5'd22, OP_PHP = 5'd23
   } alu_op_e;
endpackage

// File: rtl/alu_core.sv
module alu_core
   import alu_pkg::*;
#(
   parameter int  W            = 8,
   parameter bit  SHARED_ADDER = 1'b1
) (
   input  alu_op_e        op,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   m,
   input  logic           cin,
   output logic [W-1:0]   res,
   output logic           fn,
   output logic           fv,
   output logic           fz,
   output logic           fc
);
   localparam int MSB = W - 1;

   logic [W-1:0] addend;
   logic [W:0]   sum;

   assign addend = (op == OP_ADC) ? m : ~m;

   generate
      if (SHARED_ADDER) begin : g_shared
         logic add_cin;
         assign add_cin = (op == OP_CMP) ? 1'b1 : cin;
         assign sum = {1'b0, a} + {1'b0, addend} + {{W{1'b0}}, add_cin};
      end else begin : g_split
         logic [W:0] s_add, s_sub, s_cmp;
         assign s_add = {1'b0, a} + {1'b0, m}  + {{W{1'b0}}, cin};
         assign s_sub = {1'b0, a} + {1'b0, ~m} + {{W{1'b0}}, cin};
         assign s_cmp = {1'b0, a} + {1'b0, ~m} + {{W{1'b0}}, 1'b1};
         assign sum = (op == OP_ADC) ? s_add :
                      (op == OP_CMP) ? s_cmp : s_sub;
      end
   endgenerate

   always_comb begin
      res = a;
      fc  = cin;
      fv  = 1'b0;
      case (op)
         OP_ADC, OP_SBC: begin
            res = sum[W-1:0];
            fc  = sum[W];
            fv  = (a[MSB] == addend[MSB]) && (sum[MSB] != a[MSB]);
         end
         OP_AND: res = a & m;
         OP_ORA: res = a | m;
         OP_EOR: res = a ^ m;
         OP_ASL: begin res = {m[MSB-1:0], 1'b0}; fc = m[MSB]; end
         OP_LSR: begin res = {1'b0, m[MSB:1]};   fc = m[0];   end
         OP_ROL: begin res = {m[MSB-1:0], cin};  fc = m[MSB]; end
         OP_ROR: begin res = {cin, m[MSB:1]};    fc = m[0];   end
         OP_CMP: fc = sum[W];
         OP_INC: res = m + 1'b1;
         OP_DEC: res = m - 1'b1;
         OP_LDM, OP_TXS: res = m;
         OP_BIT: fv = m[MSB-1];
         default: ;
      endcase
      case (op)
         OP_CMP: begin fn = sum[MSB]; fz = (sum[W-1:0] == '0); end
         OP_BIT: begin fn = m[MSB];   fz = ((a & m) == '0);    end
         default: begin fn = res[MSB]; fz = (res == '0);       end
      endcase
   end
endmodule

// File: rtl/alu_flag_merge.sv
module alu_flag_merge
   import alu_pkg::*;
(
   input  alu_op_e            op,
   input  logic [STAT_W-1:0]  stat_q,
   input  logic [STAT_W-1:0]  pulled,
   input  logic               fn,
   input  logic               fv,
   input  logic               fz,
   input  logic               fc,
   output logic [STAT_W-1:0]  stat_d
);
   always_comb begin
      stat_d = stat_q;
      case (op)
         OP_ADC, OP_SBC: begin
            stat_d[SBIT_N] = fn; stat_d[SBIT_V] = fv;
            stat_d[SBIT_Z] = fz; stat_d[SBIT_C] = fc;
         end
         OP_AND, OP_ORA, OP_EOR, OP_INC, OP_DEC, OP_LDM: begin
            stat_d[SBIT_N] = fn; stat_d[SBIT_Z] = fz;
         end
         OP_BIT: begin
            stat_d[SBIT_N] = fn; stat_d[SBIT_V] = fv; stat_d[SBIT_Z] = fz;
         end
         OP_ASL, OP_LSR, OP_ROL, OP_ROR, OP_CMP: begin
            stat_d[SBIT_N] = fn; stat_d[SBIT_Z] = fz; stat_d[SBIT_C] = fc;
         end
         OP_CLC: stat_d[SBIT_C] = 1'b0;
         OP_SEC: stat_d[SBIT_C] = 1'b1;
         OP_CLI: stat_d[SBIT_I] = 1'b0;
         OP_SEI: stat_d[SBIT_I] = 1'b1;
         OP_CLD: stat_d[SBIT_D] = 1'b0;
         OP_SED: stat_d[SBIT_D] = 1'b1;
         OP_CLV: stat_d[SBIT_V] = 1'b0;
         OP_PLP: stat_d = pulled;
         default: ;
      endcase
      stat_d[SBIT_K] = 1'b1;
      stat_d[SBIT_B] = 1'b0;
   end
endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
   import alu_pkg::*;
#(
   parameter int W              = 8,
   parameter bit SHARED_ADDER   = 1'b1,
   parameter bit RESET_IRQ_MASK = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          op_valid,
   input  logic [4:0]    op_i,
   input  logic [W-1:0]  a_i,
   input  logic [W-1:0]  m_i,
   output logic [W-1:0]  result_o,
   output logic [7:0]    status_o
);
   localparam logic [STAT_W-1:0] RESET_STAT =
      (STAT_W'(1) << SBIT_K) | (STAT_W'(RESET_IRQ_MASK) << SBIT_I);
   localparam int PAD = W - STAT_W;

   generate
      if (W < STAT_W) begin : g_bad_width
         $error("acc_alu_flags: W must be at least the status width");
      end
   endgenerate

   alu_op_e             op;
   logic [STAT_W-1:0]   stat_q, stat_d;
   logic [W-1:0]        core_res;
   logic                fn, fv, fz, fc;

   assign op = alu_op_e'(op_i);

   alu_core #(.W(W), .SHARED_ADDER(SHARED_ADDER)) u_core (
      .op(op), .a(a_i), .m(m_i), .cin(stat_q[SBIT_C]),
      .res(core_res), .fn(fn), .fv(fv), .fz(fz), .fc(fc)
   );

   alu_flag_merge u_merge (
      .op(op), .stat_q(stat_q), .pulled(m_i[STAT_W-1:0]),
      .fn(fn), .fv(fv), .fz(fz), .fc(fc), .stat_d(stat_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stat_q <= RESET_STAT;
      else if (op_valid) stat_q <= stat_d;
   end

   generate
      if (PAD > 0) begin : g_pad
         assign result_o = (op == OP_PHP)
            ? {{PAD{1'b0}}, stat_q | (STAT_W'(1) << SBIT_B)} : core_res;
      end else begin : g_nopad
         assign result_o = (op == OP_PHP)
            ? (stat_q | (STAT_W'(1) << SBIT_B)) : core_res;
      end
   endgenerate

   assign status_o = stat_q;
endmodule

// File: rtl/acc_alu_flags_chk.sv
module acc_alu_flags_chk
   import alu_pkg::*;
#(
   parameter int W = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          op_valid,
   input logic [4:0]    op_i,
   input logic [W-1:0]  a_i,
   input logic [W-1:0]  m_i,
   input logic [W-1:0]  result_o,
   input logic [7:0]    status_o
);
   // R2
   fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[SBIT_K] && !status_o[SBIT_B]);

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(status_o));

   // R9
   txs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_i == OP_TXS) |=> $stable(status_o));

   // R9
   clc_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_i == OP_CLC) |=>
         !status_o[SBIT_C] && status_o[7:1] == $past(status_o[7:1]));

   // R6
   bit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_i == OP_BIT) |=>
         status_o[SBIT_N] == $past(m_i[W-1]) &&
         status_o[SBIT_V] == $past(m_i[W-2]) &&
         status_o[SBIT_C] == $past(status_o[SBIT_C]));

   // R5
   nz_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_i == OP_AND || op_i == OP_ORA || op_i == OP_EOR ||
                    op_i == OP_INC || op_i == OP_DEC || op_i == OP_LDM)) |=>
         status_o[SBIT_V] == $past(status_o[SBIT_V]) &&
         status_o[SBIT_D] == $past(status_o[SBIT_D]) &&
         status_o[SBIT_I] == $past(status_o[SBIT_I]) &&
         status_o[SBIT_C] == $past(status_o[SBIT_C]));

   // R8
   cmp_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_i == OP_CMP) |=>
         status_o[SBIT_C] == ($past(a_i) >= $past(m_i)) &&
         status_o[SBIT_Z] == ($past(a_i) == $past(m_i)));

   // R8
   cmp_keeps_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_CMP) |-> result_o == a_i);
endmodule

bind acc_alu_flags acc_alu_flags_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_i(op_i),
   .a_i(a_i), .m_i(m_i), .result_o(result_o), .status_o(status_o)
);

// File: tb/sim_acc_alu_flags.sv
module sim_acc_alu_flags;
   localparam int CLK_P = 10;
   localparam int NVEC  = 21;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [4:0] op_i = '0;
   logic [7:0] a_i = '0, m_i = '0;
   logic [7:0] result_o, status_o;
   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   acc_alu_flags u0 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_i(op_i),
      .a_i(a_i), .m_i(m_i), .result_o(result_o), .status_o(status_o)
   );

   // {req, pre-status, op, a, m, expected result, expected status}
   localparam logic [55:0] VEC [NVEC] = '{
      {8'd4,  8'h20, 8'd0,  8'h50, 8'h50, 8'hA0, 8'hE0},  // R4 signed overflow
      {8'd4,  8'h21, 8'd0,  8'hFF, 8'h00, 8'h00, 8'h23},  // R4 carry in wraps
      {8'd4,  8'h21, 8'd1,  8'h50, 8'hB0, 8'hA0, 8'hE0},  // R4 borrow + V
      {8'd4,  8'h20, 8'd1,  8'h05, 8'h03, 8'h01, 8'h21},  // R4 C=0 borrows one
      {8'd5,  8'hC3, 8'd2,  8'hF0, 8'h0F, 8'h00, 8'h63},  // R5 V,C kept
      {8'd5,  8'h20, 8'd4,  8'hFF, 8'h7F, 8'h80, 8'hA0},  // R5
      {8'd6,  8'h20, 8'd5,  8'h01, 8'hC0, 8'h01, 8'hE2},  // R6
      {8'd7,  8'h20, 8'd6,  8'h00, 8'h81, 8'h02, 8'h21},  // R7
      {8'd7,  8'hA0, 8'd7,  8'h00, 8'h01, 8'h00, 8'h23},  // R7
      {8'd7,  8'h21, 8'd8,  8'h00, 8'h80, 8'h01, 8'h21},  // R7
      {8'd7,  8'h21, 8'd9,  8'h00, 8'h02, 8'h81, 8'hA0},  // R7
      {8'd8,  8'h20, 8'd10, 8'h40, 8'h40, 8'h40, 8'h23},  // R8 equal
      {8'd8,  8'h20, 8'd10, 8'h10, 8'h20, 8'h10, 8'hA0},  // R8 less
      {8'd5,  8'h20, 8'd11, 8'h00, 8'hFF, 8'h00, 8'h22},  // R5 inc wrap
      {8'd5,  8'h20, 8'd12, 8'h00, 8'h00, 8'hFF, 8'hA0},  // R5 dec wrap
      {8'd9,  8'hCF, 8'd14, 8'h00, 8'h00, 8'h00, 8'hEF},  // R9 transfer
      {8'd9,  8'hFF, 8'd21, 8'h12, 8'h00, 8'h12, 8'hAF},  // R9 clear V
      {8'd9,  8'h20, 8'd20, 8'h00, 8'h00, 8'h00, 8'h28},  // R9 set D
      {8'd10, 8'hC3, 8'd23, 8'h00, 8'h00, 8'hF3, 8'hE3},  // R10 push
      {8'd10, 8'h20, 8'd22, 8'h00, 8'h10, 8'h00, 8'h20},  // R10 pull
      {8'd5,  8'h20, 8'd13, 8'h00, 8'h00, 8'h00, 8'h22}   // R5 load zero
   };

   function automatic string req_name(input int n);
      case (n)
         1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
         5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
         9: return "R9";  10: return "R10"; default: return "R11";
      endcase
   endfunction

   task automatic check(input string req, input logic [7:0] act, exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_op(input logic [4:0] op, input logic [7:0] a, m,
                         output logic [7:0] r, output logic [7:0] s);
      @(negedge clk);
      op_valid = 1'b1; op_i = op; a_i = a; m_i = m;
      #1 r = result_o;
      @(negedge clk);
      op_valid = 1'b0;
      s = status_o;
   endtask

   function automatic logic [15:0] ref_model(input logic [4:0] op,
                                             input logic [7:0] a, m, s);
      int t, sv;
      logic [7:0] r, ns;
      logic c;
      r = a; ns = s; c = s[0];
      case (op)
         5'd0: begin
            t = int'(a) + int'(m) + int'(c); r = t[7:0]; ns[0] = (t > 255);
            sv = int'($signed(a)) + int'($signed(m)) + int'(c);
            ns[6] = (sv > 127) || (sv < -128);
            ns[7] = r[7]; ns[1] = (r == 0);
         end
         5'd1: begin
            t = int'(a) - int'(m) - (1 - int'(c)); r = t[7:0]; ns[0] = (t >= 0);
            sv = int'($signed(a)) - int'($signed(m)) - (1 - int'(c));
            ns[6] = (sv > 127) || (sv < -128);
            ns[7] = r[7]; ns[1] = (r == 0);
         end
         5'd2, 5'd3, 5'd4, 5'd11, 5'd12, 5'd13: begin
            case (op)
               5'd2: r = a & m;   5'd3: r = a | m;  5'd4: r = a ^ m;
               5'd11: r = m + 8'd1; 5'd12: r = m - 8'd1; default: r = m;
            endcase
            ns[7] = r[7]; ns[1] = (r == 0);
         end
         5'd5: begin ns[7] = m[7]; ns[6] = m[6]; ns[1] = ((a & m) == 0); end
         5'd6, 5'd7, 5'd8, 5'd9: begin
            case (op)
               5'd6: begin r = m << 1; ns[0] = m[7]; end
               5'd7: begin r = m >> 1; ns[0] = m[0]; end
               5'd8: begin r = (m << 1) | {7'd0, c}; ns[0] = m[7]; end
               default: begin r = (m >> 1) | {c, 7'd0}; ns[0] = m[0]; end
            endcase
            ns[7] = r[7]; ns[1] = (r == 0);
         end
         5'd10: begin
            t = int'(a) - int'(m);
            ns[0] = (t >= 0); ns[1] = (t == 0); ns[7] = t[7];
         end
         5'd14: r = m;
         5'd15: ns[0] = 1'b0;  5'd16: ns[0] = 1'b1;
         5'd17: ns[2] = 1'b0;  5'd18: ns[2] = 1'b1;
         5'd19: ns[3] = 1'b0;  5'd20: ns[3] = 1'b1;
         5'd21: ns[6] = 1'b0;
         5'd22: ns = (m | 8'h20) & 8'hEF;
         5'd23: r = s | 8'h10;
         default: ;
      endcase
      return {r, ns};
   endfunction

   initial begin
      logic [7:0] r, s, es;
      logic [15:0] exp;
      // R1 reset value
      #(CLK_P*2);
      check("R1", status_o, 8'h24);
      @(negedge clk); rst_n = 1'b1;

      // table walk
      for (int i = 0; i < NVEC; i++) begin
         run_op(5'd22, 8'h00, VEC[i][47:40], r, s);
         run_op(VEC[i][36:32], VEC[i][31:24], VEC[i][23:16], r, s);
         check(req_name(int'(VEC[i][55:48])), r, VEC[i][15:8]);
         check(req_name(int'(VEC[i][55:48])), s, VEC[i][7:0]);
      end

      // R3 operation presented without op_valid leaves status untouched
      run_op(5'd22, 8'h00, 8'h00, r, s);
      @(negedge clk);
      op_i = 5'd16; m_i = 8'hFF; a_i = 8'h33;
      #1 check("R3", result_o, 8'h33);
      @(negedge clk);
      check("R3", status_o, 8'h20);

      // R2 pull of all ones still reads bit 5 set, bit 4 clear
      run_op(5'd22, 8'h00, 8'hFF, r, s);
      check("R2", s, 8'hEF);

      // R11 unused codes
      run_op(5'd27, 8'h5A, 8'h00, r, s);
      check("R11", r, 8'h5A);
      check("R11", s, 8'hEF);

      // R9 flag clears one at a time
      run_op(5'd15, 8'h00, 8'h00, r, s); check("R9", s, 8'hEE);
      run_op(5'd17, 8'h00, 8'h00, r, s); check("R9", s, 8'hEA);
      run_op(5'd19, 8'h00, 8'h00, r, s); check("R9", s, 8'hE2);
      run_op(5'd18, 8'h00, 8'h00, r, s); check("R9", s, 8'hE6);

      // R4 R5 R6 R7 R8 R10 randomised against the bench model
      for (int k = 0; k < 400; k++) begin
         logic [7:0] pre, a, m;
         logic [4:0] op;
         pre = 8'($urandom); a = 8'($urandom); m = 8'($urandom);
         op = 5'($urandom_range(0, 31));
         run_op(5'd22, 8'h00, pre, r, s);
         es = (pre | 8'h20) & 8'hEF;
         exp = ref_model(op, a, m, es);
         run_op(op, a, m, r, s);
         check("R4", r, exp[15:8]);
         check("R4", s, exp[7:0]);
      end

      // R1 reset mid-run
      @(negedge clk); rst_n = 1'b0;
      #1 check("R1", status_o, 8'h24);

      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(CLK_P*100000);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule